// File: doc/BRIEF.md
# Rounding Fixed-Point Sequential Divider

This block divides one signed fixed-point value by another. Both operands and the result share a single format with a compile-time number of fraction bits (`FRAC_W`, 8 by default, on a 16-bit word). The quotient is rounded to the nearest representable value rather than simply chopped.

The block first widens the dividend to double width and shifts it up by the fraction count, so that the quotient keeps its fraction bits. It then biases the widened dividend by half the divisor, toward or away from zero as the operand signs dictate, and runs a truncating restoring division on magnitudes. This loop produces one quotient bit per clock. The result is the low word of the signed quotient, with no clamping.

A caller raises `start` for one cycle while the block is idle. The block reports `busy` until it finishes, then pulses `done` with the quotient on `quotient`. A zero divisor ends the operation at once with a clamped value and a flag.

Top module: `fxq_divider`

## Requirements
- R1: The dividend is sign-extended to 32 bits and shifted left by FRAC_W (8) bits before division, so a quotient of operands in the same format is in that format (0x0300 / 0x0200 gives 0x0180).
- R2: When the pre-scaled dividend and the divisor agree in sign (both ≥ 0 or both < 0), half the divisor is added to the pre-scaled dividend before dividing (0x0001 / 0x0200 gives 0x0001; 0xFE00 / 0xFF00 gives 0x0200).
- R3: When their signs differ, half the divisor is subtracted instead (0x0001 / 0xFE00 gives 0xFFFF).
- R4: Half the divisor is the divisor shifted right arithmetically by one bit, so an odd negative divisor rounds its half toward minus infinity (0xFFFF / 0xFFFD gives 0x0056).
- R5: The biased dividend is divided with the quotient truncated toward zero (0xFFFF / 0x0005 gives 0xFFCD, not 0xFFCC).
- R6: The result is the low 16 bits of the 32-bit signed quotient, with no saturation (0x7FFF / 0x0001 gives 0xFF00).
- R7: A zero divisor skips iteration. `done` and `div_by_zero` rise on the cycle after acceptance. The quotient is 0x7FFF when the dividend's bit 15 is 0 and 0x8000 when it is 1. The flag clears when the next operation is accepted.
- R8: For a non-zero divisor, `done` is high for exactly one cycle, 33 cycles after the accepting clock edge (32 iteration cycles). The quotient is valid in that cycle and is held until the next completion.
- R9: `start` is ignored while `busy` is high. It changes neither the running operation's result nor its completion time.
- R10: A synchronous reset returns the block to idle with `busy`, `done` and `div_by_zero` low and `quotient` zero, even in the middle of an operation.
- R11: `busy` is high from the cycle after acceptance through the `done` cycle inclusive, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an operation; sampled only while idle |
| dividend | input | 16 | Signed fixed-point numerator |
| divisor | input | 16 | Signed fixed-point denominator |
| busy | output | 1 | Operation in progress, including the done cycle |
| done | output | 1 | One-cycle pulse; quotient is valid |
| quotient | output | 16 | Rounded signed quotient, held between operations |
| div_by_zero | output | 1 | Last accepted operation had a zero divisor |

## Verification
The bound checker watches several properties on every cycle:
- the one-cycle shape of `done`, and that `busy` covers it;
- that `busy` cannot drop mid-run;
- that the quotient stays still until completion;
- the 33-cycle latency, counted from acceptance;
- the immediate clamped answer for a zero divisor.

The arithmetic itself is shown only by the bench's scenarios. These cover the sign-dependent bias direction, the arithmetic halving of odd negative divisors, truncation toward zero and the unsaturated wrap. The same holds for rejecting a second `start` and for a reset in mid-operation. A behavioural model compares every output on each clock.

// File: rtl/fxq_pkg.sv
package fxq_pkg;

    // Controller phases of the divider
    typedef enum logic [1:0] {
        FXQ_IDLE = 2'd0,
        FXQ_RUN  = 2'd1,
        FXQ_DONE = 2'd2
    } fxq_state_e;

endpackage

// File: rtl/fxq_prescale.sv
// Widens and scales the dividend, applies the sign-dependent half-divisor
// bias and splits the operands into magnitudes plus a quotient sign.
module fxq_prescale #(
    parameter int DATA_W = 16,
    parameter int FRAC_W = 8
) (
    input  logic [DATA_W-1:0]   num_in,
    input  logic [DATA_W-1:0]   den_in,
    output logic [2*DATA_W-1:0] num_mag,
    output logic [DATA_W-1:0]   den_mag,
    output logic                quo_neg,
    output logic                den_zero,
    output logic                num_neg
);
    localparam int WIDE_W = 2 * DATA_W;

    logic [WIDE_W-1:0] scaled;
    logic [WIDE_W-1:0] half_den;
    logic [WIDE_W-1:0] biased;
    logic              same_sign;

    always_comb begin
        scaled    = {{(WIDE_W-DATA_W){num_in[DATA_W-1]}}, num_in} << FRAC_W;
        half_den  = {{(WIDE_W-DATA_W+1){den_in[DATA_W-1]}}, den_in[DATA_W-1:1]};
        same_sign = (scaled[WIDE_W-1] == den_in[DATA_W-1]);
        biased    = same_sign ? (scaled + half_den) : (scaled - half_den);
        num_mag   = biased[WIDE_W-1] ? (~biased + 1'b1) : biased;
        den_mag   = den_in[DATA_W-1] ? (~den_in + 1'b1) : den_in;
        quo_neg   = biased[WIDE_W-1] ^ den_in[DATA_W-1];
        den_zero  = (den_in == '0);
        num_neg   = num_in[DATA_W-1];
    end
endmodule

// File: rtl/fxq_step.sv
// One restoring-division step: shift in the next numerator bit, try the
// subtraction, keep it when it does not go negative.
module fxq_step #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] rem_in,
    input  logic              bit_in,
    input  logic [DATA_W-1:0] den,
    output logic [DATA_W-1:0] rem_out,
    output logic              q_bit
);
    logic [DATA_W:0] shifted;

    always_comb begin
        shifted = {rem_in, bit_in};
        q_bit   = (shifted >= {1'b0, den});
        rem_out = q_bit ? DATA_W'(shifted - {1'b0, den}) : shifted[DATA_W-1:0];
    end
endmodule

// File: rtl/fxq_finish.sv
// Restores the quotient sign and keeps the low word (no clamping).
module fxq_finish #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] mag_lo,
    input  logic              neg,
    output logic [DATA_W-1:0] result
);
    always_comb begin
        result = neg ? (~mag_lo + 1'b1) : mag_lo;
    end
endmodule

// File: rtl/fxq_divider.sv
module fxq_divider #(
    parameter int DATA_W = 16,
    parameter int FRAC_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [DATA_W-1:0] dividend,
    input  logic [DATA_W-1:0] divisor,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] quotient,
    output logic              div_by_zero
);
    import fxq_pkg::*;

    localparam int WIDE_W = 2 * DATA_W;
    localparam int CNT_W  = $clog2(WIDE_W);
    localparam logic [CNT_W-1:0]  LAST_STEP = CNT_W'(WIDE_W - 1);
    localparam logic [DATA_W-1:0] CLAMP_POS = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] CLAMP_NEG = {1'b1, {(DATA_W-1){1'b0}}};

    typedef struct packed {
        fxq_state_e        st;
        logic [WIDE_W-1:0] quo;
        logic [DATA_W-1:0] rem;
        logic [DATA_W-1:0] dmag;
        logic              neg;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] result;
        logic              dbz;
    } fxq_regs_t;

    fxq_regs_t r_q, r_d;

    logic [WIDE_W-1:0] pre_num_mag;
    logic [DATA_W-1:0] pre_den_mag;
    logic              pre_quo_neg;
    logic              pre_den_zero;
    logic              pre_num_neg;
    logic [DATA_W-1:0] step_rem;
    logic              step_bit;
    logic [WIDE_W-1:0] quo_step;
    logic [DATA_W-1:0] fin_result;

    fxq_prescale #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_prescale (
        .num_in   (dividend),
        .den_in   (divisor),
        .num_mag  (pre_num_mag),
        .den_mag  (pre_den_mag),
        .quo_neg  (pre_quo_neg),
        .den_zero (pre_den_zero),
        .num_neg  (pre_num_neg)
    );

    fxq_step #(.DATA_W(DATA_W)) u_step (
        .rem_in  (r_q.rem),
        .bit_in  (r_q.quo[WIDE_W-1]),
        .den     (r_q.dmag),
        .rem_out (step_rem),
        .q_bit   (step_bit)
    );

    assign quo_step = {r_q.quo[WIDE_W-2:0], step_bit};

    fxq_finish #(.DATA_W(DATA_W)) u_finish (
        .mag_lo (quo_step[DATA_W-1:0]),
        .neg    (r_q.neg),
        .result (fin_result)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            FXQ_IDLE: begin
                if (start) begin
                    r_d.dbz = 1'b0;
                    if (pre_den_zero) begin
                        r_d.st     = FXQ_DONE;
                        r_d.result = pre_num_neg ? CLAMP_NEG : CLAMP_POS;
                        r_d.dbz    = 1'b1;
                    end else begin
                        r_d.st   = FXQ_RUN;
                        r_d.quo  = pre_num_mag;
                        r_d.rem  = '0;
                        r_d.dmag = pre_den_mag;
                        r_d.neg  = pre_quo_neg;
                        r_d.cnt  = '0;
                    end
                end
            end
            FXQ_RUN: begin
                r_d.quo = quo_step;
                r_d.rem = step_rem;
                if (r_q.cnt == LAST_STEP) begin
                    r_d.st     = FXQ_DONE;
                    r_d.result = fin_result;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            FXQ_DONE: begin
                r_d.st = FXQ_IDLE;
            end
            default: begin
                r_d.st = FXQ_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '{st: FXQ_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy        = (r_q.st != FXQ_IDLE);
    assign done        = (r_q.st == FXQ_DONE);
    assign quotient    = r_q.result;
    assign div_by_zero = r_q.dbz;
endmodule

// File: rtl/fxq_divider_chk.sv
module fxq_divider_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              dividend_msb,
    input logic [DATA_W-1:0] divisor,
    input logic              busy,
    input logic              done,
    input logic [DATA_W-1:0] quotient,
    input logic              div_by_zero
);
    localparam int WIDE_W = 2 * DATA_W;
    localparam int LAT    = WIDE_W + 1;
    localparam int LW     = $clog2(LAT + 1);
    localparam logic [DATA_W-1:0] CLAMP_POS = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] CLAMP_NEG = {1'b1, {(DATA_W-1){1'b0}}};

    logic [LW-1:0] lat_q;
    logic          rst_seen_q;

    always_ff @(posedge clk) begin
        rst_seen_q <= rst;
        if (rst) begin
            lat_q <= '0;
        end else if (start && !busy && divisor != '0) begin
            lat_q <= LW'(1);
        end else if (lat_q != '0 && lat_q != LW'(LAT)) begin
            lat_q <= lat_q + 1'b1;
        end else begin
            lat_q <= '0;
        end
    end

    // R10
    always_ff @(posedge clk) begin
        if (rst_seen_q) begin
            reset_idle_chk: assert (!busy && !done && !div_by_zero && quotient == '0);
        end
    end

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R11
    done_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

    // R9
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> (busy && (done || $stable(quotient))));

    // R8
    latency_hit_chk: assert property (@(posedge clk) disable iff (rst)
        (lat_q == LW'(LAT)) |-> done);

    // R8
    latency_only_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !div_by_zero) |-> (lat_q == LW'(LAT)));

    // R7
    zero_div_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && divisor == '0) |=>
            (done && div_by_zero &&
             quotient == ($past(dividend_msb) ? CLAMP_NEG : CLAMP_POS)));
endmodule

bind fxq_divider fxq_divider_chk #(.DATA_W(DATA_W)) u_fxq_divider_chk (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .dividend_msb (dividend[DATA_W-1]),
    .divisor      (divisor),
    .busy         (busy),
    .done         (done),
    .quotient     (quotient),
    .div_by_zero  (div_by_zero)
);

// File: tb/fxq_divider_bench.sv
`timescale 1ns/1ps
module fxq_divider_bench;
    localparam int DW   = 16;
    localparam int FW   = 8;
    localparam int WDOG = 50000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [DW-1:0] dividend = '0;
    logic [DW-1:0] divisor = '0;
    logic          busy, done, div_by_zero;
    logic [DW-1:0] quotient;

    int tests = 0;
    int fails = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    fxq_divider #(.DATA_W(DW), .FRAC_W(FW)) u_fxq_divider (
        .clk(clk), .rst(rst), .start(start), .dividend(dividend),
        .divisor(divisor), .busy(busy), .done(done),
        .quotient(quotient), .div_by_zero(div_by_zero)
    );

    function automatic logic [DW-1:0] expect_q(logic [DW-1:0] a, logic [DW-1:0] b);
        longint sa, sb, t, h, bi, qq;
        if (b == '0) return a[DW-1] ? 16'h8000 : 16'h7FFF;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        t  = sa * (longint'(1) << FW);
        h  = sb >>> 1;
        bi = ((t >= 0) == (sb >= 0)) ? (t + h) : (t - h);
        qq = bi / sb;
        return qq[DW-1:0];
    endfunction

    task automatic check(string tag, string what, longint act, longint exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Behavioural reference model, advanced on each rising edge
    logic          m_busy, m_done, m_dbz;
    logic [DW-1:0] m_q, m_pend;
    int            m_cnt;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst) begin
            m_busy <= 0; m_done <= 0; m_dbz <= 0; m_q <= '0; m_cnt <= 0;
        end else if (!m_busy) begin
            m_done <= 0;
            if (start) begin
                m_busy <= 1;
                if (divisor == '0) begin
                    m_done <= 1; m_dbz <= 1; m_q <= expect_q(dividend, divisor);
                end else begin
                    m_dbz <= 0; m_cnt <= 2 * DW; m_pend <= expect_q(dividend, divisor);
                end
            end
        end else if (m_done) begin
            m_busy <= 0; m_done <= 0;
        end else begin
            if (m_cnt == 1) begin
                m_done <= 1; m_q <= m_pend;
            end
            m_cnt <= m_cnt - 1;
        end
    end

    // Per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (!rst && cyc > 0) begin
            check("R11", "busy", busy, m_busy);
            check("R8", "done", done, m_done);
            check("R1", "quotient", quotient, m_q);
            check("R7", "div_by_zero", div_by_zero, m_dbz);
        end
    end

    task automatic run_op(logic [DW-1:0] a, logic [DW-1:0] b, string tag);
        int lat;
        @(negedge clk);
        while (busy) @(negedge clk);
        start = 1'b1; dividend = a; divisor = b;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        check(tag, "result", quotient, expect_q(a, b));
        check(b == '0 ? "R7" : tag, "flag", div_by_zero, (b == '0));
        check(b == '0 ? "R7" : "R8", "latency", lat, (b == '0) ? 1 : 2 * DW + 1);
        @(negedge clk);
        check("R8", "done pulse width", done, 0);
        check("R8", "result held", quotient, expect_q(a, b));
    endtask

    initial begin
        wait (cyc >= WDOG);
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10: idle after reset
        check("R10", "busy after reset", busy, 0);
        check("R10", "done after reset", done, 0);
        check("R10", "quotient after reset", quotient, 0);
        check("R10", "flag after reset", div_by_zero, 0);

        run_op(16'h0100, 16'h0100, "R1");
        run_op(16'h0300, 16'h0200, "R1");
        check("R1", "1.5 encoding", expect_q(16'h0300, 16'h0200), 16'h0180);
        run_op(16'h0001, 16'h0200, "R2");
        run_op(16'hFE00, 16'hFF00, "R2");
        run_op(16'h0001, 16'hFE00, "R3");
        run_op(16'hFFFF, 16'hFFFD, "R4");
        run_op(16'hFFFF, 16'h0005, "R5");
        run_op(16'h7FFF, 16'h0001, "R6");
        run_op(16'h1234, 16'h0000, "R7");
        run_op(16'h8000, 16'h0000, "R7");
        run_op(16'h0000, 16'h0000, "R7");
        run_op(16'h0200, 16'h0300, "R7");   // flag clears on next accepted op
        run_op(16'h8000, 16'h8000, "R2");
        run_op(16'h7FFF, 16'hFFFF, "R6");

        // R9: a second start while busy is ignored
        @(negedge clk);
        start = 1'b1; dividend = 16'h0500; divisor = 16'h0300;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        start = 1'b1; dividend = 16'h0100; divisor = 16'h0000;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        check("R9", "result unaffected", quotient, expect_q(16'h0500, 16'h0300));
        check("R9", "flag unaffected", div_by_zero, 0);
        @(negedge clk);
        check("R9", "no restart", busy, 0);

        // R10: reset in mid-operation
        start = 1'b1; dividend = 16'h0700; divisor = 16'h0200;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R10", "busy after mid reset", busy, 0);
        check("R10", "quotient after mid reset", quotient, 0);
        run_op(16'h0700, 16'h0200, "R1");

        repeat (3) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule